// File: doc/BRIEF.md
# External Event Priority Controller

This block sits beside the sequencer of a small processor core and decides which external event, if any, the core takes up next. Six sources compete: a reset request, a cache flush request, a system-management interrupt, a non-maskable interrupt, a maskable interrupt and a stop-clock request. Apart from reset, they are only looked at while the sequencer signals an instruction boundary. The block picks one winner by fixed priority and reports it on a registered one-hot grant that lasts one cycle.

Two lock bits keep handlers from being re-entered. One covers the non-maskable handler and is released by an interrupt-return indication. The other covers the system-management handler and is released by a resume indication. A rising edge on the non-maskable line is caught in a single pending bit, so an event that lands during its own handler is replayed after the return. Granting the non-maskable event also raises a one-cycle request to clear the core's interrupt-enable flag. Stop-clock is never held back by either lock.

Top module: `evt_prio_ctrl`

## Requirements
- R1: A reset request is granted (grant bit 0) in the cycle after it is sampled, whether or not a boundary is signalled. The same edge clears both lock bits and the pending non-maskable bit.
- R2: Without a reset request and without the boundary strobe, the grant in the following cycle is all zero.
- R3: When several eligible requests meet at one boundary, the winner is chosen in this order, highest first: reset (bit 0), flush (bit 1), system-management (bit 2), non-maskable (bit 3), maskable (bit 4), stop-clock (bit 5).
- R4: The grant has at most one bit set. Each grant comes from exactly one sampled cycle and lasts one clock.
- R5: A rising edge on the non-maskable request sets the pending status one cycle later. Several edges before that pending bit is granted collapse into a single grant.
- R6: Once a non-maskable grant has been given, no further non-maskable grant is given until an interrupt-return pulse has been sampled. A boundary in the same cycle as that pulse does not yet grant it.
- R7: A non-maskable edge seen while that handler is busy stays pending. It is granted at the first boundary after the return pulse.
- R8: Once a system-management grant has been given, that event is not granted again until a resume pulse has been sampled.
- R9: The interrupt-enable clear output pulses high in the same cycle as every non-maskable grant, and at no other time.
- R10: The maskable request is granted only while the enable flag input is high. It is level-sensitive: a request dropped before a boundary leaves nothing behind.
- R11: Stop-clock is granted at a boundary while either handler lock is set, provided no higher request is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Reset event request |
| flush_req | input | 1 | Cache flush request |
| smi_req | input | 1 | System-management interrupt request, level |
| nmi_req | input | 1 | Non-maskable interrupt request, edge-detected |
| intr_req | input | 1 | Maskable interrupt request, level |
| stpclk_req | input | 1 | Stop-clock request |
| boundary | input | 1 | Instruction-boundary strobe |
| ie_flag | input | 1 | Current interrupt-enable flag of the core |
| iret_done | input | 1 | Interrupt-return pulse |
| rsm_done | input | 1 | System-management resume pulse |
| grant_o | output | 6 | One-hot dispatch grant, bit order as in R3 |
| ie_clear_o | output | 1 | Request to clear the interrupt-enable flag |
| nmi_pend_o | output | 1 | Non-maskable event pending |
| nmi_busy_o | output | 1 | Non-maskable handler in service |
| smi_busy_o | output | 1 | System-management handler in service |

## Verification
The pair that can fall in one cycle is the interrupt-return pulse and an instruction boundary while a non-maskable request is pending. The bench drives both in one cycle after several edges have been gathered during service. It expects no grant in that cycle, and a single non-maskable grant with an enable-clear pulse at the next boundary. A per-cycle behavioural model judges this together with stop-clock grants issued while the locks are held.

// File: rtl/evt_prio_pkg.sv
package evt_prio_pkg;
  localparam int EVT_N      = 6;
  localparam int IDX_RESET  = 0;
  localparam int IDX_FLUSH  = 1;
  localparam int IDX_SMI    = 2;
  localparam int IDX_NMI    = 3;
  localparam int IDX_INTR   = 4;
  localparam int IDX_STPCLK = 5;

  // one-hot mask for an event index
  function automatic logic [EVT_N-1:0] evt_bit(input int idx);
    logic [EVT_N-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/evt_nmi_track.sv
module evt_nmi_track (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic clr,
  input  logic take,
  input  logic iret,
  output logic pend,
  output logic busy,
  output logic ready
);
  logic req_d;
  logic rise;

  assign rise  = nmi_req & ~req_d;
  assign ready = pend & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      pend  <= 1'b0;
      busy  <= 1'b0;
    end else begin
      req_d <= nmi_req;
      if (clr) begin
        pend <= 1'b0;
        busy <= 1'b0;
      end else begin
        pend <= (pend & ~take) | rise;
        busy <= (busy & ~iret) | take;
      end
    end
  end

  assert_pend_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr) |=> pend);
  assert_busy_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !iret && !clr) |=> busy);
endmodule

// File: rtl/evt_smi_lock.sv
module evt_smi_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic rsm,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   busy <= 1'b0;
    else if (clr) busy <= 1'b0;
    else          busy <= (busy & ~rsm) | take;
  end

  assert_lock_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsm && !clr) |=> busy);
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win
);
  logic [N:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win[i]     = req[i] & ~above[i];
    assign above[i+1] = above[i] | req[i];
  end

  always_comb begin
    assert_single_win_R4: assert ($onehot0(win));
  end
endmodule

// File: rtl/evt_prio_ctrl.sv
module evt_prio_ctrl
  import evt_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic             flush_req,
  input  logic             smi_req,
  input  logic             nmi_req,
  input  logic             intr_req,
  input  logic             stpclk_req,
  input  logic             boundary,
  input  logic             ie_flag,
  input  logic             iret_done,
  input  logic             rsm_done,
  output logic [EVT_N-1:0] grant_o,
  output logic             ie_clear_o,
  output logic             nmi_pend_o,
  output logic             nmi_busy_o,
  output logic             smi_busy_o
);
  logic [EVT_N-1:0] cand;
  logic [EVT_N-1:0] win;
  logic [EVT_N-1:0] grant_q;
  logic             ie_clr_q;
  logic             nmi_ready_w;
  logic             nmi_busy_w;
  logic             nmi_pend_w;
  logic             smi_busy_w;

  always_comb begin
    cand             = '0;
    cand[IDX_RESET]  = rst_req;
    cand[IDX_FLUSH]  = boundary & flush_req;
    cand[IDX_SMI]    = boundary & smi_req & ~smi_busy_w;
    cand[IDX_NMI]    = boundary & nmi_ready_w;
    cand[IDX_INTR]   = boundary & intr_req & ie_flag;
    cand[IDX_STPCLK] = boundary & stpclk_req;
  end

  evt_arbiter #(.N(EVT_N)) arb_i (
    .req (cand),
    .win (win)
  );

  evt_nmi_track nmi_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_req (nmi_req),
    .clr     (win[IDX_RESET]),
    .take    (win[IDX_NMI]),
    .iret    (iret_done),
    .pend    (nmi_pend_w),
    .busy    (nmi_busy_w),
    .ready   (nmi_ready_w)
  );

  evt_smi_lock smi_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win[IDX_RESET]),
    .take  (win[IDX_SMI]),
    .rsm   (rsm_done),
    .busy  (smi_busy_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      ie_clr_q <= 1'b0;
    end else begin
      grant_q  <= win;
      ie_clr_q <= win[IDX_NMI];
    end
  end

  assign grant_o    = grant_q;
  assign ie_clear_o = ie_clr_q;
  assign nmi_pend_o = nmi_pend_w;
  assign nmi_busy_o = nmi_busy_w;
  assign smi_busy_o = smi_busy_w;

  assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (grant_q == evt_bit(IDX_RESET)) && !nmi_busy_w && !smi_busy_w && !nmi_pend_w);
  assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !boundary) |=> (grant_q == '0));
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  assert_nmi_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_busy_w |=> !grant_q[IDX_NMI]);
  assert_smi_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smi_busy_w |=> !grant_q[IDX_SMI]);
  assert_ie_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_busy_w) |-> ie_clr_q);
  assert_intr_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_flag |=> !grant_q[IDX_INTR]);
endmodule

// File: tb/evt_prio_ctrl_tb.sv
module evt_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_req = 0, flush_req = 0, smi_req = 0, nmi_req = 0, intr_req = 0;
  logic       stpclk_req = 0, boundary = 0, ie_flag = 0, iret_done = 0, rsm_done = 0;
  logic [5:0] grant_o;
  logic       ie_clear_o, nmi_pend_o, nmi_busy_o, smi_busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_grant = -1;
  bit m_ieclr = 0, m_pend = 0, m_busy = 0, m_smi = 0, m_nmid = 0;

  always #10 clk = ~clk;

  evt_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .flush_req(flush_req),
    .smi_req(smi_req), .nmi_req(nmi_req), .intr_req(intr_req),
    .stpclk_req(stpclk_req), .boundary(boundary), .ie_flag(ie_flag),
    .iret_done(iret_done), .rsm_done(rsm_done), .grant_o(grant_o),
    .ie_clear_o(ie_clear_o), .nmi_pend_o(nmi_pend_o),
    .nmi_busy_o(nmi_busy_o), .smi_busy_o(smi_busy_o)
  );

  task automatic expect_v(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    bit edge_n;
    int g;
    edge_n = nmi_req && !m_nmid;
    g = -1;
    if (rst_req) g = 0;
    else if (boundary) begin
      if (flush_req) g = 1;
      else if (smi_req && !m_smi) g = 2;
      else if (m_pend && !m_busy) g = 3;
      else if (intr_req && ie_flag) g = 4;
      else if (stpclk_req) g = 5;
    end
    if (g == 0) begin
      m_busy = 0; m_smi = 0; m_pend = 0;
    end else begin
      m_smi  = (m_smi && !rsm_done) || g == 2;
      m_busy = (m_busy && !iret_done) || g == 3;
      m_pend = (m_pend && g != 3) || edge_n;
    end
    m_nmid  = nmi_req;
    m_grant = g;
    m_ieclr = (g == 3);
  endtask

  function automatic int gvec(input int g);
    return (g < 0) ? 0 : (1 << g);
  endfunction

  task automatic compare(input string tag);
    expect_v({tag, " grant"}, grant_o, gvec(m_grant));
    expect_v("R9 ie_clear", ie_clear_o, m_ieclr);
    expect_v({tag, " pend"}, nmi_pend_o, m_pend);
    expect_v({tag, " nmi_busy"}, nmi_busy_o, m_busy);
    expect_v({tag, " smi_busy"}, smi_busy_o, m_smi);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_v("R1 reset grant", grant_o, 0);
    expect_v("R1 reset busy", nmi_busy_o | smi_busy_o | nmi_pend_o, 0);
    rst_n = 1'b1;
    ie_flag = 1;
    step("R2");

    // R2: requests without a boundary give nothing
    flush_req = 1; smi_req = 1; intr_req = 1; stpclk_req = 1;
    step("R2"); expect_v("R2 no boundary", grant_o, 0);
    flush_req = 0; smi_req = 0; intr_req = 0; stpclk_req = 0;

    // R5 / R9: edge, then grant
    nmi_req = 1; step("R5"); expect_v("R5 pend set", nmi_pend_o, 1);
    nmi_req = 0; boundary = 1; step("R9");
    expect_v("R9 nmi grant", grant_o, 6'h08); expect_v("R9 clr pulse", ie_clear_o, 1);
    boundary = 0; step("R6"); expect_v("R9 clr off", ie_clear_o, 0);

    // R5 collapse during service, R6 lock
    for (int k = 0; k < 3; k++) begin
      nmi_req = 1; step("R5"); nmi_req = 0; step("R5");
    end
    expect_v("R5 pend while busy", nmi_pend_o, 1);
    boundary = 1; step("R6"); expect_v("R6 locked", grant_o, 0);
    stpclk_req = 1; step("R11"); expect_v("R11 stop under nmi", grant_o, 6'h20);
    stpclk_req = 0;
    iret_done = 1; step("R6"); expect_v("R6 same-cycle return", grant_o, 0);
    iret_done = 0; step("R7"); expect_v("R7 replay", grant_o, 6'h08);
    boundary = 0; iret_done = 1; step("R7"); iret_done = 0; step("R7");
    boundary = 1; step("R5"); expect_v("R5 collapsed to one", grant_o, 0);
    boundary = 0;

    // R8 system-management lock
    smi_req = 1; boundary = 1; step("R8"); expect_v("R8 smi grant", grant_o, 6'h04);
    step("R8"); expect_v("R8 locked", grant_o, 0);
    stpclk_req = 1; step("R11"); expect_v("R11 stop under smi", grant_o, 6'h20);
    stpclk_req = 0; boundary = 0; rsm_done = 1; step("R8"); rsm_done = 0;
    boundary = 1; step("R8"); expect_v("R8 after resume", grant_o, 6'h04);
    smi_req = 0; boundary = 0; rsm_done = 1; step("R8"); rsm_done = 0;

    // R10 maskable
    ie_flag = 0; intr_req = 1; boundary = 1; step("R10"); expect_v("R10 masked", grant_o, 0);
    ie_flag = 1; step("R10"); expect_v("R10 enabled", grant_o, 6'h10);
    boundary = 0; step("R10");
    intr_req = 0; boundary = 1; step("R10"); expect_v("R10 not latched", grant_o, 0);
    boundary = 0;

    // R3 priority ladder
    iret_done = 1; step("R3"); iret_done = 0;
    nmi_req = 1; step("R3"); nmi_req = 0;
    flush_req = 1; smi_req = 1; intr_req = 1; stpclk_req = 1; boundary = 1;
    step("R3"); expect_v("R3 flush first", grant_o, 6'h02);
    flush_req = 0; step("R3"); expect_v("R3 smi next", grant_o, 6'h04);
    step("R3"); expect_v("R3 nmi next", grant_o, 6'h08);
    step("R10"); expect_v("R10 intr after nmi", grant_o, 6'h10);
    intr_req = 0; step("R3"); expect_v("R3 stop last", grant_o, 6'h20);

    // R1 reset in any cycle, clears locks
    boundary = 0; flush_req = 1; smi_req = 1; nmi_req = 1; rst_req = 1;
    step("R1"); expect_v("R1 reset grant", grant_o, 6'h01);
    expect_v("R1 locks clear", nmi_busy_o | smi_busy_o | nmi_pend_o, 0);
    boundary = 1; step("R1"); expect_v("R1 over flush", grant_o, 6'h01);
    rst_req = 0; flush_req = 0; nmi_req = 0;
    step("R1"); expect_v("R1 smi unlocked", grant_o, 6'h04);
    boundary = 0; smi_req = 0; stpclk_req = 0;
    step("R4");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule